// File: doc/BRIEF.md
# SMI Enable and Status Register Pair

This block holds the two 32-bit registers that steer system-management interrupts inside a power-management I/O window. One is an enable word that firmware writes; the other is a status word that records which events occurred. Both are reached through a simple 32-bit bus port with a byte offset, strobed reads and writes, and byte enables. Only full-word accesses are accepted.

Software's control of the enable word is limited in two ways. A write mask, loaded through a configuration port that is not on the bus, selects which enable bits a bus write may change. A lock input from the watchdog block freezes the watchdog-enable bit against bus writes. The reset value also depends on a strap: when the platform has no SMM support, the APM-command enable bit comes out of reset set, so firmware treats the SMM handler as already initialised.

Status bits are set by per-bit event inputs and cleared by per-bit clear strobes. Bus writes cannot change them. Both registers also drive output ports for the SMI generation logic that follows this block.

Top module: `smi_ctl_regs`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears the enable word to zero and sets the write mask to all ones. The exception is bit 5, the APM-command enable bit, which resets to 1 when smm_present is 0. The status word and bus_rdata reset to zero.
- R2: A full-word read at byte offset 0 returns the enable word. At offset 4 it returns the status word. At any other offset it returns zero. Data appears on bus_rdata at the clock edge that samples bus_rd and holds until the next read.
- R3: An access is full-word only when all four byte enables are 1. A write with any other byte-enable value changes nothing. A read with any other byte-enable value returns zero.
- R4: A full-word write at offset 0 sets the enable word to (old & ~mask) | (data & mask) at the clock edge that samples bus_wr. A read in the same cycle returns the old value.
- R5: While wdog_lock is 1, an enable write leaves bit 13, the watchdog-enable bit, at its current value. All other masked bits take the written data.
- R6: While wdog_lock is 0, bit 13 is written like any other masked bit.
- R7: Writes at offset 4 do not change the status word.
- R8: At each clock edge, status bit i is set when evt_set[i] is 1. It is cleared when evt_clr[i] is 1 and evt_set[i] is 0. Otherwise it holds, so a set wins over a clear in the same cycle.
- R9: cfg_mask_we loads cfg_mask_data into the write mask at the clock edge. The mask holds until the next load or reset.
- R10: smi_en and smi_sts always show the current enable and status words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smm_present | input | 1 | Strap: 1 when SMM is supported |
| bus_addr | input | 8 | Byte offset of the access |
| bus_be | input | 4 | Byte enables; all ones for a valid access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wdog_lock | input | 1 | Watchdog lock; freezes enable bit 13 |
| cfg_mask_we | input | 1 | Write-mask load strobe |
| cfg_mask_data | input | 32 | New write mask |
| evt_set | input | 32 | Per-bit status set events |
| evt_clr | input | 32 | Per-bit status clear strobes |
| smi_en | output | 32 | Current enable word |
| smi_sts | output | 32 | Current status word |

## Verification
The bench reads all offsets in a small window and expects zero wherever nothing is decoded. A decoder that ignored low address bits would alias the enable word there. It sweeps every partial byte-enable pattern on both writes and reads, which catches a design that accepts sub-word accesses. Thirty-two rotated masks with varied data expose any merge that inverts the mask or leaks unmasked bits. The bench toggles bit 13 in both directions with the lock set and clear. It resets with the SMM strap in both states, and it drives set and clear together on the same status bits, where a clear-wins design would lose events.

// File: rtl/smi_regs_pkg.sv
package smi_regs_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_EN   = 2'd1,
      SEL_STS  = 2'd2
   } smi_sel_e;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/smi_bus_decode.sv
module smi_bus_decode
   import smi_regs_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned BE_W    = 4,
   parameter int unsigned EN_OFF  = 0,
   parameter int unsigned STS_OFF = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [BE_W-1:0]   be,
   input  logic              rd,
   input  logic              wr,
   output smi_sel_e          sel,
   output logic              full,
   output logic              en_wr,
   output logic              rd_go
);
   localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(EN_OFF);
   localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFF);

   if (EN_OFF == STS_OFF) begin : g_bad_overlap
      $error("enable and status offsets coincide");
   end
   if ((EN_OFF % BE_W) != 0 || (STS_OFF % BE_W) != 0) begin : g_bad_align
      $error("register offsets must be word aligned");
   end
   if (EN_OFF >= (1 << ADDR_W) || STS_OFF >= (1 << ADDR_W)) begin : g_bad_range
      $error("register offset outside address range");
   end

   assign full = &be;

   always_comb begin
      if (addr == EN_A)       sel = SEL_EN;
      else if (addr == STS_A) sel = SEL_STS;
      else                    sel = SEL_NONE;
   end

   assign en_wr = wr && full && (sel == SEL_EN);
   assign rd_go = rd;
endmodule

// File: rtl/smi_enable_reg.sv
module smi_enable_reg #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned WDOG_BIT = 13,
   parameter int unsigned APM_BIT  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smm_present,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              lock,
   input  logic              mask_we,
   input  logic [DATA_W-1:0] mask_d,
   output logic [DATA_W-1:0] en_q
);
   if (WDOG_BIT >= DATA_W || APM_BIT >= DATA_W) begin : g_bad_bit
      $error("special enable bit outside data width");
   end
   if (WDOG_BIT == APM_BIT) begin : g_bad_same
      $error("watchdog and APM bits must differ");
   end

   logic [DATA_W-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '1;
      else if (mask_we) mask_q <= mask_d;
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      logic nxt;
      logic rst_val;
      logic q;

      if (b == WDOG_BIT) begin : g_lockable
         assign nxt = lock ? q : wdata[b];
      end else begin : g_plain
         assign nxt = wdata[b];
      end

      if (b == APM_BIT) begin : g_apm
         assign rst_val = ~smm_present;
      end else begin : g_zero
         assign rst_val = 1'b0;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)                  q <= rst_val;
         else if (wr_en && mask_q[b]) q <= nxt;
      end

      assign en_q[b] = q;
   end
endmodule

// File: rtl/smi_status_reg.sv
module smi_status_reg #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set,
   input  logic [DATA_W-1:0] clr,
   output logic [DATA_W-1:0] sts_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) sts_q <= '0;
      else        sts_q <= (sts_q & ~clr) | set;
   end
endmodule

// File: rtl/smi_ctl_regs.sv
module smi_ctl_regs
   import smi_regs_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned EN_OFF   = 0,
   parameter int unsigned STS_OFF  = 4,
   parameter int unsigned WDOG_BIT = 13,
   parameter int unsigned APM_BIT  = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     smm_present,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [DATA_W/BYTE_W-1:0] bus_be,
   input  logic                     bus_rd,
   input  logic                     bus_wr,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   input  logic                     wdog_lock,
   input  logic                     cfg_mask_we,
   input  logic [DATA_W-1:0]        cfg_mask_data,
   input  logic [DATA_W-1:0]        evt_set,
   input  logic [DATA_W-1:0]        evt_clr,
   output logic [DATA_W-1:0]        smi_en,
   output logic [DATA_W-1:0]        smi_sts
);
   localparam int unsigned BE_W = DATA_W / BYTE_W;

   if (DATA_W % BYTE_W != 0) begin : g_bad_width
      $error("data width must be a whole number of bytes");
   end

   smi_sel_e sel;
   logic     full;
   logic     en_wr;
   logic     rd_go;

   smi_bus_decode #(
      .ADDR_W (ADDR_W),
      .BE_W   (BE_W),
      .EN_OFF (EN_OFF),
      .STS_OFF(STS_OFF)
   ) u_dec (
      .addr (bus_addr),
      .be   (bus_be),
      .rd   (bus_rd),
      .wr   (bus_wr),
      .sel  (sel),
      .full (full),
      .en_wr(en_wr),
      .rd_go(rd_go)
   );

   smi_enable_reg #(
      .DATA_W  (DATA_W),
      .WDOG_BIT(WDOG_BIT),
      .APM_BIT (APM_BIT)
   ) u_en (
      .clk        (clk),
      .rst_n      (rst_n),
      .smm_present(smm_present),
      .wr_en      (en_wr),
      .wdata      (bus_wdata),
      .lock       (wdog_lock),
      .mask_we    (cfg_mask_we),
      .mask_d     (cfg_mask_data),
      .en_q       (smi_en)
   );

   smi_status_reg #(
      .DATA_W(DATA_W)
   ) u_sts (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (evt_set),
      .clr  (evt_clr),
      .sts_q(smi_sts)
   );

   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      unique case (sel)
         SEL_EN:  rd_mux = smi_en;
         SEL_STS: rd_mux = smi_sts;
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     bus_rdata <= '0;
      else if (rd_go) bus_rdata <= full ? rd_mux : '0;
   end
endmodule

// File: rtl/smi_ctl_regs_chk.sv
module smi_ctl_regs_chk #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned EN_OFF   = 0,
   parameter int unsigned STS_OFF  = 4,
   parameter int unsigned WDOG_BIT = 13
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [ADDR_W-1:0]      bus_addr,
   input logic [DATA_W/8-1:0]    bus_be,
   input logic                   bus_rd,
   input logic                   bus_wr,
   input logic [DATA_W-1:0]      bus_rdata,
   input logic                   wdog_lock,
   input logic [DATA_W-1:0]      evt_set,
   input logic [DATA_W-1:0]      smi_en,
   input logic [DATA_W-1:0]      smi_sts
);
   logic past_ok;
   always_ff @(posedge clk) past_ok <= rst_n;

   logic full_c, en_wr_c, known_c;
   assign full_c  = &bus_be;
   assign en_wr_c = bus_wr && full_c && (bus_addr == ADDR_W'(EN_OFF));
   assign known_c = (bus_addr == ADDR_W'(EN_OFF)) || (bus_addr == ADDR_W'(STS_OFF));

   AST_EN_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(en_wr_c)) |-> $stable(smi_en)); // R4

   AST_LOCK_FREEZES_WDOG: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(en_wr_c && wdog_lock)) |-> (smi_en[WDOG_BIT] == $past(smi_en[WDOG_BIT]))); // R5

   AST_EVENT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (($past(evt_set) & ~smi_sts) == '0)); // R8

   AST_STATUS_RISES_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> ((smi_sts & ~$past(smi_sts) & ~$past(evt_set)) == '0)); // R7

   AST_UNDECODED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(bus_rd && !known_c)) |-> (bus_rdata == '0)); // R2

   AST_PARTIAL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(bus_rd && !full_c)) |-> (bus_rdata == '0)); // R3
endmodule

bind smi_ctl_regs smi_ctl_regs_chk #(
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .EN_OFF  (EN_OFF),
   .STS_OFF (STS_OFF),
   .WDOG_BIT(WDOG_BIT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_be   (bus_be),
   .bus_rd   (bus_rd),
   .bus_wr   (bus_wr),
   .bus_rdata(bus_rdata),
   .wdog_lock(wdog_lock),
   .evt_set  (evt_set),
   .smi_en   (smi_en),
   .smi_sts  (smi_sts)
);

// File: tb/smi_ctl_regs_test.sv
module smi_ctl_regs_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smm_present = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wdog_lock = 1'b0;
   logic        cfg_mask_we = 1'b0;
   logic [31:0] cfg_mask_data = '0;
   logic [31:0] evt_set = '0;
   logic [31:0] evt_clr = '0;
   logic [31:0] smi_en;
   logic [31:0] smi_sts;

   smi_ctl_regs uut (
      .clk(clk), .rst_n(rst_n), .smm_present(smm_present),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdog_lock(wdog_lock),
      .cfg_mask_we(cfg_mask_we), .cfg_mask_data(cfg_mask_data),
      .evt_set(evt_set), .evt_clr(evt_clr), .smi_en(smi_en), .smi_sts(smi_sts)
   );

   always #10 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] exp_en, exp_sts, exp_mask;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic smm);
      @(negedge clk);
      smm_present = smm;
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      exp_en   = smm ? 32'h0 : 32'h0000_0020;
      exp_sts  = '0;
      exp_mask = '1;
   endtask

   task automatic do_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
      logic [31:0] dd;
      bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
      if (be == 4'hF && a == 8'd0) begin
         dd = d;
         if (wdog_lock) dd[13] = exp_en[13];
         exp_en = (exp_en & ~exp_mask) | (dd & exp_mask);
      end
   endtask

   task automatic do_read(input logic [7:0] a, input logic [3:0] be, input string req);
      logic [31:0] e;
      if (be != 4'hF)     e = '0;
      else if (a == 8'd0) e = exp_en;
      else if (a == 8'd4) e = exp_sts;
      else                e = '0;
      bus_addr = a; bus_be = be; bus_rd = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_rd = 1'b0;
      chk(req, bus_rdata, e);
   endtask

   task automatic set_mask(input logic [31:0] m);
      cfg_mask_data = m; cfg_mask_we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cfg_mask_we = 1'b0;
      exp_mask = m;
   endtask

   task automatic pulse_evt(input logic [31:0] s, input logic [31:0] c);
      evt_set = s; evt_clr = c;
      @(posedge clk);
      @(negedge clk);
      evt_set = '0; evt_clr = '0;
      exp_sts = (exp_sts & ~c) | s;
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      // R1: reset without SMM support sets APM bit
      do_reset(1'b0);
      chk("R1 en no-smm", smi_en, 32'h0000_0020);
      chk("R1 sts", smi_sts, 32'h0);
      chk("R1 rdata", bus_rdata, 32'h0);
      do_read(8'd0, 4'hF, "R1 read en");
      // R1: reset with SMM support
      do_reset(1'b1);
      chk("R1 en smm", smi_en, 32'h0);
      // R1/R9: mask comes up all ones
      do_write(8'd0, 4'hF, 32'hFFFF_FFFF);
      do_read(8'd0, 4'hF, "R1 mask all ones");
      chk("R10 smi_en port", smi_en, exp_en);

      // R2: offset sweep with nonzero status
      pulse_evt(32'h1234_8001, 32'h0);
      for (int a = 0; a < 16; a++) do_read(8'(a), 4'hF, "R2 offset sweep");
      do_read(8'd128, 4'hF, "R2 far offset");
      chk("R10 smi_sts port", smi_sts, exp_sts);

      // R4: same-cycle read returns old value
      bus_addr = 8'd0; bus_be = 4'hF; bus_wdata = 32'h0; bus_wr = 1'b1; bus_rd = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      chk("R4 read before write", bus_rdata, exp_en);
      exp_en = 32'h0;
      chk("R4 write landed", smi_en, exp_en);

      // R3: partial byte enables on write and read
      for (int b = 0; b < 15; b++) begin
         do_write(8'd0, 4'(b), 32'hDEAD_BEEF ^ 32'(b));
         chk("R3 partial write ignored", smi_en, exp_en);
         do_read(8'd4, 4'(b), "R3 partial read zero");
      end

      // R4/R9: mask sweep
      for (int i = 0; i < 32; i++) begin
         logic [31:0] p, m, d;
         p = 32'hA5C3_0F96;
         m = (p << i) | (p >> (32 - i));
         d = 32'h9E37_79B9 * 32'(i + 1);
         set_mask(m);
         do_write(8'd0, 4'hF, d);
         do_read(8'd0, 4'hF, "R4 masked merge");
      end
      set_mask(32'h0);
      do_write(8'd0, 4'hF, ~exp_en);
      chk("R9 zero mask blocks", smi_en, exp_en);

      // R5/R6: watchdog lock
      set_mask('1);
      do_write(8'd0, 4'hF, 32'h0000_0000);
      wdog_lock = 1'b1;
      do_write(8'd0, 4'hF, 32'h0000_2F00);
      chk("R5 lock keeps bit13 low", smi_en, 32'h0000_0F00);
      wdog_lock = 1'b0;
      do_write(8'd0, 4'hF, 32'h0000_2000);
      chk("R6 unlocked bit13 set", smi_en, 32'h0000_2000);
      wdog_lock = 1'b1;
      do_write(8'd0, 4'hF, 32'h0000_00F0);
      chk("R5 lock keeps bit13 high", smi_en, 32'h0000_20F0);
      wdog_lock = 1'b0;
      do_write(8'd0, 4'hF, 32'h0000_0001);
      chk("R6 unlocked bit13 clear", smi_en, 32'h0000_0001);

      // R7: status writes ignored
      do_write(8'd4, 4'hF, 32'hFFFF_FFFF);
      chk("R7 sts write ones", smi_sts, exp_sts);
      do_write(8'd4, 4'hF, 32'h0);
      do_read(8'd4, 4'hF, "R7 sts write zero");

      // R8: set, clear, set-wins
      pulse_evt(32'h0, 32'h0000_8001);
      chk("R8 clear", smi_sts, 32'h1234_0000);
      pulse_evt(32'h00F0_0000, 32'h00F0_0000);
      chk("R8 set wins", smi_sts, 32'h12F4_0000);
      pulse_evt(32'h0000_0003, 32'h1000_0000);
      do_read(8'd4, 4'hF, "R8 mixed");

      // R9: reset restores mask
      set_mask(32'h0);
      do_reset(1'b1);
      do_write(8'd0, 4'hF, 32'hCAFE_F00D);
      chk("R9 mask restored", smi_en, 32'hCAFE_F00D);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule